// File: doc/BRIEF.md
# Smartcard Character Transmitter with Automatic Retry

This block sends single characters to a smartcard over one shared, open-drain data line. A byte is handed over on a valid/ready handshake. The block then frames it in time units of one ETU: a low start bit, eight data bits in a chosen order, and an even parity bit. After that it releases the line for a guard time, so the whole character takes 11 or 12 ETU. One ETU is a fixed number of pulses of an oversampling tick supplied from outside.

In the T=0 character protocol the card reports a parity error by pulling the line low during the first guard ETU. The block samples the line at the middle of that ETU. When it sees such a rejection it sends the same byte again, with no help from outside, until the card accepts it or the programmed number of resends has been used. In the T=1 protocol the line is never sampled, and each character is sent exactly once. A one-cycle completion pulse reports success. A separate one-cycle pulse reports that the character was dropped after the last allowed resend.

Top module: `sc_char_tx`

## Requirements
- R1: `data_ready` is high exactly while the block is idle. A byte is taken on a clock edge where `data_valid` and `data_ready` are both high. `data_ready` stays low until the whole character sequence, including any resends, has finished.
- R2: The start bit (line driven low) begins in the cycle after acceptance. Every ETU lasts OVS pulses of `os_tick`. ETU 0 is the start bit, ETUs 1 to 8 carry the data, ETU 9 carries the parity bit, and the line is released in every later ETU.
- R3: With `msb_first`=0, data bit 0 goes out in ETU 1 and bit 7 in ETU 8. With `msb_first`=1, bit 7 goes out in ETU 1 and bit 0 in ETU 8.
- R4: The parity bit in ETU 9 makes the number of ones across the eight data bits and the parity bit even.
- R5: With `long_guard`=0 a character lasts 11 ETU. With `long_guard`=1 it lasts 12 ETU. The result of an attempt is known at the end of its last ETU.
- R6: With `proto_t1`=0 (T=0), a low `line_in` at the middle tick (tick OVS/2) of ETU 10 marks the attempt as rejected.
- R7: A rejected T=0 attempt is followed at once by a resend of the same byte, with the same framing. The new start bit begins in the cycle after the previous attempt ends. At most `retry_max` resends are made.
- R8: When an attempt is rejected and `retry_max` resends have already been made, the block pulses `retry_exhausted` for one cycle, does not pulse `done`, drops the byte and goes idle.
- R9: With `proto_t1`=1, `line_in` is ignored. A low line in ETU 10 causes no resend, and `done` follows the single attempt.
- R10: An accepted character gives a one-cycle `done` pulse in the cycle after its last ETU ends. `data_ready` is high in that same cycle. `done` and `retry_exhausted` are never high together.
- R11: `proto_t1`, `long_guard`, `msb_first`, `retry_max` and the data byte are captured at acceptance. Changes to these inputs during a character sequence have no effect on it.
- R12: `line_drive_low` is high only while a zero bit (start, data or parity) is being sent. It is never high while the block is idle.
- R13: After reset, `data_ready`=1, `line_drive_low`=0, `done`=0 and `retry_exhausted`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling pulse; OVS pulses make one ETU |
| proto_t1 | input | 1 | 0 = T=0 with rejection and resend, 1 = T=1 |
| long_guard | input | 1 | 0 = 11 ETU character, 1 = 12 ETU character |
| msb_first | input | 1 | 1 = most significant data bit sent first |
| retry_max | input | RETRY_W | Largest number of resends after rejection |
| data_in | input | DATA_W | Byte to send |
| data_valid | input | 1 | `data_in` is offered |
| data_ready | output | 1 | Block idle, byte can be accepted |
| line_in | input | 1 | Level of the shared data line |
| line_drive_low | output | 1 | Open-drain pull-down enable for the data line |
| done | output | 1 | One-cycle pulse: character accepted by the card |
| retry_exhausted | output | 1 | One-cycle pulse: character dropped after final rejection |

## Verification
The bench drives `os_tick` every cycle with OVS=4. The acceptance edge is time zero for each attempt. The bit of ETU k must appear on `line_drive_low` 4k+2 cycles after that edge. The outcome pulse comes exactly 4L cycles after it, where L is 11 or 12, and a resend's start bit shows in that same cycle. The card model pulls the line for the whole of ETU 10. The two-stage input synchronizer then delivers the low level exactly at the mid-ETU sample. Every check samples at the falling clock edge of its own computed cycle. The pulse checks look again one cycle later to confirm the pulse has ended.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

   typedef enum logic [1:0] {
      END_NONE   = 2'd0,
      END_DONE   = 2'd1,
      END_RETRY  = 2'd2,
      END_GIVEUP = 2'd3
   } end_e;

   function automatic logic even_parity8(input logic [7:0] d);
      return ^d;
   endfunction

endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
   parameter int OVS    = 16,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic              tick,
   output logic [SLOT_W-1:0] slot,
   output logic              sub_mid,
   output logic              etu_last
);
   localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
   localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2);

   logic [SUB_W-1:0] sub;

   assign sub_mid  = run && tick && (sub == SUB_MID);
   assign etu_last = run && tick && (sub == SUB_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub  <= '0;
         slot <= '0;
      end else if (start) begin
         sub  <= '0;
         slot <= '0;
      end else if (run && tick) begin
         if (sub == SUB_LAST) begin
            sub  <= '0;
            slot <= slot + 1'b1;
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sc_tx_bitsel.sv
module sc_tx_bitsel #(
   parameter int DATA_W = 8,
   parameter int SLOT_W = 4
) (
   input  logic [DATA_W-1:0] data,
   input  logic              msb_first,
   input  logic [SLOT_W-1:0] slot,
   output logic              bit_o
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [SLOT_W-1:0] SLOT_LAST_DATA = SLOT_W'(DATA_W);
   localparam logic [SLOT_W-1:0] SLOT_PAR       = SLOT_W'(DATA_W + 1);

   logic [DATA_W-1:0] rev;
   logic [DATA_W-1:0] ordered;
   logic              par;

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign rev[i] = data[DATA_W-1-i];
   end

   assign ordered = msb_first ? rev : data;
   assign par     = ^data;

   always_comb begin
      bit_o = 1'b1;
      if (slot == '0)
         bit_o = 1'b0;
      else if (slot <= SLOT_LAST_DATA)
         bit_o = ordered[IDX_W'(slot - 1'b1)];
      else if (slot == SLOT_PAR)
         bit_o = par;
   end
endmodule

// File: rtl/sc_tx_retry.sv
module sc_tx_retry
   import sc_tx_pkg::*;
#(
   parameter int RETRY_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               nack_in,
   input  logic               frame_end,
   input  logic [RETRY_W-1:0] limit,
   output end_e               dec
);
   logic               nack_q;
   logic [RETRY_W-1:0] resends;

   always_comb begin
      dec = END_NONE;
      if (frame_end) begin
         if (nack_q)
            dec = (resends == limit) ? END_GIVEUP : END_RETRY;
         else
            dec = END_DONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nack_q  <= 1'b0;
         resends <= '0;
      end else if (clear) begin
         nack_q  <= 1'b0;
         resends <= '0;
      end else if (dec == END_RETRY) begin
         nack_q  <= 1'b0;
         resends <= resends + 1'b1;
      end else if (nack_in) begin
         nack_q <= 1'b1;
      end
   end
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
   import sc_tx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int RETRY_W     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               os_tick,
   input  logic               proto_t1,
   input  logic               long_guard,
   input  logic               msb_first,
   input  logic [RETRY_W-1:0] retry_max,
   input  logic [DATA_W-1:0]  data_in,
   input  logic               data_valid,
   output logic               data_ready,
   input  logic               line_in,
   output logic               line_drive_low,
   output logic               done,
   output logic               retry_exhausted
);
   localparam int SLOT_W = $clog2(DATA_W + 4);
   localparam logic [SLOT_W-1:0] SLOT_NACK  = SLOT_W'(DATA_W + 2);
   localparam logic [SLOT_W-1:0] SLOT_END11 = SLOT_W'(DATA_W + 2);
   localparam logic [SLOT_W-1:0] SLOT_END12 = SLOT_W'(DATA_W + 3);

   if (DATA_W != 8) begin : g_bad_width
      $error("sc_char_tx: DATA_W must be 8 for character framing");
   end
   if (OVS < 4) begin : g_bad_ovs
      $error("sc_char_tx: OVS must be at least 4");
   end
   if (RETRY_W < 1) begin : g_bad_retry
      $error("sc_char_tx: RETRY_W must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > OVS / 2) begin : g_bad_sync
      $error("sc_char_tx: SYNC_STAGES must lie in 0..OVS/2");
   end

   logic               busy;
   logic [DATA_W-1:0]  data_q;
   logic               t1_q, g12_q, msb_q;
   logic [RETRY_W-1:0] rmax_q;
   logic [SLOT_W-1:0]  slot;
   logic               sub_mid, etu_last;
   logic               tx_bit;
   logic               line_s;
   logic               accept, restart, frame_end, nack_hit;
   logic               done_q, exh_q;
   end_e               dec;

   // Line input synchronizer: depth chosen by parameter
   if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = line_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else begin
            sh[0] <= line_in;
            for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
         end
      end
      assign line_s = sh[SYNC_STAGES-1];
   end

   assign accept    = data_valid && !busy;
   assign restart   = accept || (dec == END_RETRY);
   assign frame_end = busy && etu_last && (slot == (g12_q ? SLOT_END12 : SLOT_END11));
   assign nack_hit  = busy && !t1_q && sub_mid && (slot == SLOT_NACK) && !line_s;

   sc_etu_timer #(.OVS(OVS), .SLOT_W(SLOT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (restart),
      .run     (busy),
      .tick    (os_tick),
      .slot    (slot),
      .sub_mid (sub_mid),
      .etu_last(etu_last)
   );

   sc_tx_bitsel #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_bitsel (
      .data     (data_q),
      .msb_first(msb_q),
      .slot     (slot),
      .bit_o    (tx_bit)
   );

   sc_tx_retry #(.RETRY_W(RETRY_W)) u_retry (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .nack_in  (nack_hit),
      .frame_end(frame_end),
      .limit    (rmax_q),
      .dec      (dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         data_q <= '0;
         t1_q   <= 1'b0;
         g12_q  <= 1'b0;
         msb_q  <= 1'b0;
         rmax_q <= '0;
         done_q <= 1'b0;
         exh_q  <= 1'b0;
      end else begin
         done_q <= (dec == END_DONE);
         exh_q  <= (dec == END_GIVEUP);
         if (accept) begin
            busy   <= 1'b1;
            data_q <= data_in;
            t1_q   <= proto_t1;
            g12_q  <= long_guard;
            msb_q  <= msb_first;
            rmax_q <= retry_max;
         end else if (dec == END_DONE || dec == END_GIVEUP) begin
            busy <= 1'b0;
         end
      end
   end

   assign data_ready      = !busy;
   assign line_drive_low  = busy && !tx_bit;
   assign done            = done_q;
   assign retry_exhausted = exh_q;
endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic data_valid,
   input logic data_ready,
   input logic line_drive_low,
   input logic done,
   input logic retry_exhausted
);
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready |-> !line_drive_low); // R12
   AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && data_ready) |=> (line_drive_low && !data_ready)); // R2
   AST_READY_ONLY_ON_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> (done || retry_exhausted)); // R1
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> data_ready); // R10
   AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && retry_exhausted)); // R8
   AST_EXHAUST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      retry_exhausted |=> !retry_exhausted); // R8
endmodule

bind sc_char_tx sc_char_tx_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .data_valid     (data_valid),
   .data_ready     (data_ready),
   .line_drive_low (line_drive_low),
   .done           (done),
   .retry_exhausted(retry_exhausted)
);

// File: tb/sc_char_tx_test.sv
`timescale 1ns/1ps
module sc_char_tx_test;
   localparam int OVS     = 4;
   localparam int RETRY_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic os_tick = 1'b1;
   logic proto_t1 = 1'b0, long_guard = 1'b0, msb_first = 1'b0;
   logic [RETRY_W-1:0] retry_max = '0;
   logic [7:0] data_in = '0;
   logic data_valid = 1'b0;
   logic data_ready, line_drive_low, done, retry_exhausted;
   logic card_pull = 1'b0;
   wire  line = !(line_drive_low || card_pull);

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sc_char_tx #(.DATA_W(8), .OVS(OVS), .RETRY_W(RETRY_W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .proto_t1(proto_t1),
      .long_guard(long_guard), .msb_first(msb_first), .retry_max(retry_max),
      .data_in(data_in), .data_valid(data_valid), .data_ready(data_ready),
      .line_in(line), .line_drive_low(line_drive_low), .done(done),
      .retry_exhausted(retry_exhausted)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Expected drive (1 = pulled low) for ETU k of a character
   function automatic bit exp_drive(input logic [7:0] d, input bit msb, input int k);
      if (k == 0) return 1'b1;
      if (k >= 1 && k <= 8) return !(msb ? d[8-k] : d[k-1]);
      if (k == 9) return !(^d);
      return 1'b0;
   endfunction

   task automatic send_char(input logic [7:0] d, input bit t1, input bit g12,
                            input bit msb, input int rmax, input int nacks);
      int len = g12 ? 12 : 11;
      bit fin = 0;
      proto_t1 = t1; long_guard = g12; msb_first = msb;
      retry_max = RETRY_W'(rmax); data_in = d; data_valid = 1'b1;
      chk(data_ready == 1'b1, "R1 ready idle", data_ready, 1);
      @(negedge clk);
      data_valid = 1'b0;
      // R11: scramble settings after acceptance
      proto_t1 = ~t1; long_guard = ~g12; msb_first = ~msb;
      retry_max = RETRY_W'($urandom); data_in = 8'($urandom);
      for (int a = 0; !fin; a++) begin
         bit nk = (a < nacks);
         for (int n = 0; n < len * OVS; n++) begin
            card_pull = nk && (n >= 10 * OVS) && (n < 11 * OVS);
            if (n % OVS == OVS / 2) begin
               int k = n / OVS;
               bit e = exp_drive(d, msb, k);
               chk(line_drive_low == e, (k >= 1 && k <= 8) ? "R3 data bit" :
                   (k == 9) ? "R4 parity" : "R2 framing", line_drive_low, e);
               if (k == 0) chk(data_ready == 1'b0, "R1 busy", data_ready, 0);
               if (k == len - 1) chk(done == 1'b0, "R5 length", done, 0);
            end
            @(negedge clk);
         end
         card_pull = 1'b0;
         if (!t1 && nk) begin
            if (a == rmax) begin
               chk(retry_exhausted == 1'b1, "R8 exhausted", retry_exhausted, 1);
               chk(done == 1'b0, "R8 no done", done, 0);
               chk(data_ready == 1'b1, "R8 idle", data_ready, 1);
               fin = 1;
            end else begin
               chk(done == 1'b0 && retry_exhausted == 1'b0, "R7 no outcome", done, 0);
               chk(line_drive_low == 1'b1, "R7 resend start", line_drive_low, 1);
               chk(data_ready == 1'b0, "R7 still busy", data_ready, 0);
            end
         end else begin
            chk(done == 1'b1, t1 ? "R9 done" : "R10 done", done, 1);
            chk(retry_exhausted == 1'b0, "R10 no exhaust", retry_exhausted, 0);
            chk(data_ready == 1'b1, "R10 ready", data_ready, 1);
            fin = 1;
         end
      end
      @(negedge clk);
      chk(done == 1'b0 && retry_exhausted == 1'b0, "R10 pulse ends", done, 0);
      chk(line_drive_low == 1'b0, "R12 released idle", line_drive_low, 0);
   endtask

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      chk(data_ready == 1'b1, "R13 ready", data_ready, 1);
      chk(line_drive_low == 1'b0, "R13 line", line_drive_low, 0);
      chk(done == 1'b0 && retry_exhausted == 1'b0, "R13 status", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // Directed corners
      send_char(8'hA5, 1'b0, 1'b0, 1'b0, 2, 0);   // R2 R4 R5 plain
      send_char(8'h01, 1'b0, 1'b1, 1'b1, 2, 0);   // R3 msb first, R5 12 ETU
      send_char(8'h3C, 1'b0, 1'b0, 1'b0, 0, 1);   // R8 no resends allowed
      send_char(8'hF0, 1'b0, 1'b1, 1'b0, 3, 3);   // R6 R7 accepted on last try
      send_char(8'h7E, 1'b0, 1'b0, 1'b1, 3, 4);   // R8 exhausted after 3
      send_char(8'h81, 1'b1, 1'b0, 1'b0, 2, 2);   // R9 T=1 ignores pull
      send_char(8'h00, 1'b1, 1'b1, 1'b1, 0, 0);   // R4 zero byte
      // Constrained random
      for (int i = 0; i < 40; i++) begin
         int rm = $urandom_range(0, 3);
         send_char(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   rm, $urandom_range(0, rm + 1));
         repeat ($urandom_range(0, 3)) @(negedge clk);
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule